// File: doc/BRIEF.md
# Machine-Check and Checkstop Controller

This block sits at the edge of a processor's bus logic. It watches two asynchronous active-low inputs: a machine-check request and a checkstop request. Two configuration bits decide what a machine-check event does:

- **Interrupt.** A machine-check enable and an external machine-check enable both set turn a qualified event into a one-cycle interrupt request.
- **Halt.** With only the external enable set, the same event halts the processor.
- **Nothing.** With the external enable clear, the event has no effect.

A checkstop request cannot be masked and always halts.

While halted, the block drops a clock-enable output. It also drops an output-enable, so that every other bus output floats. It drives an open-drain status line low, which is the only output still active. Only the synchronous hard reset brings the block out of the halted state.

Both requests pass through multi-flop synchronizers. A machine-check event counts only if the synchronized request stays low for a minimum number of bus clocks, counted from its falling edge.

Top module: `mchk_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `clk_en` and `out_en` are 1, `cs_out_oe` is 0, `cs_out_n` is released (high impedance) and `mc_irq` is 0.
- R2: A low level on `mc_in_n` counts as a machine-check event only after the synchronized request has been low for `HOLD_CYC` (default 2) consecutive clock samples. A shorter low pulse has no effect in any configuration.
- R3: With `cfg_me`=1 and `cfg_emc`=1, each qualified event gives exactly one `mc_irq` pulse of one cycle, however long the request stays low. A further pulse needs `mc_in_n` to return high and then fall again.
- R4: With `cfg_emc`=1 and `cfg_me`=0, a qualified event enters the halted state and raises no `mc_irq`.
- R5: With `cfg_emc`=0, machine-check events are ignored: no `mc_irq` and no halt.
- R6: `cs_in_n` low for one clock or more enters the halted state, whatever the values of `cfg_me` and `cfg_emc`.
- R7: In the halted state `clk_en`=0, `out_en`=0 and `cs_out_oe`=1, and `cs_out_n` is driven to 0. `cs_out_n` is never driven to 1. It is either 0 or high impedance.
- R8: The halted state persists after both requests are released, and `mc_irq` stays 0 while halted. Only `rst_n` low leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| mc_in_n | input | 1 | Asynchronous active-low machine-check request |
| cs_in_n | input | 1 | Asynchronous active-low checkstop request |
| cfg_me | input | 1 | Machine-check enable |
| cfg_emc | input | 1 | External machine-check enable |
| mc_irq | output | 1 | One-cycle machine-check interrupt request |
| clk_en | output | 1 | Core clock enable, 0 while halted |
| out_en | output | 1 | Bus output enable, 0 while halted |
| cs_out_oe | output | 1 | Drive enable of the open-drain status line |
| cs_out_n | output | 1 | Open-drain checkstop status, 0 or high impedance |

## Verification
The assertions assume the following about the inputs:

- The configuration bits are quasi-static around an event, so the enables seen when an event qualifies are the ones that decide its outcome.
- `rst_n` is a clean synchronous level.

The stimulus respects this. It changes the enables and both requests only on the falling clock edge, and it changes the enables only while both requests are idle and the synchronizers have settled. It leaves at least ten idle cycles between events. The status line is read through a pulled-up net, so a released line reads 1.

// File: rtl/mchk_pkg.sv
// Package: shared types for the machine-check and checkstop controller.
// Assumes nothing beyond being compiled before the modules that use it.
package mchk_pkg;

    // Operating state of the controller.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } mchk_state_e;

endpackage

// File: rtl/mchk_sync.sv
// Module: mchk_sync
// Brings an asynchronous level into the clock domain through a chain of
// flops. Assumes STAGES >= 2. Resets to RST_VAL, the inactive level of the
// request it carries.
module mchk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mchk_qual.sv
// Module: mchk_qual
// Qualifies a synchronized active-low request. It counts consecutive low
// samples from the falling edge and emits one pulse when the count reaches
// HOLD_CYC. The counter then saturates, so the pulse does not repeat until
// the request returns high. Assumes the input is already synchronized and
// that HOLD_CYC >= 1.
module mchk_qual #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic evt
);

    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(HOLD_CYC);

    logic [CW-1:0] low_cnt;

    // Count low samples, saturating at HOLD_CYC and clearing on a high sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (req_n) begin
            low_cnt <= '0;
        end else if (low_cnt != SAT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Emit the single qualification pulse on the HOLD_CYC-th low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else begin
            evt <= !req_n && (low_cnt == LAST);
        end
    end

    // R3: the event is a single-cycle pulse.
    a_r3_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);

    generate
        if (HOLD_CYC >= 2) begin : g_hold_chk
            // R2: an event implies the request was already low two samples back.
            a_r2_evt_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
                evt |-> !$past(req_n, 2));
        end
    endgenerate

endmodule

// File: rtl/mchk_fsm.sv
// Module: mchk_fsm
// Decides the outcome of qualified events and holds the sticky halted
// state. A checkstop request always halts. A machine-check event either
// interrupts, halts or is dropped, depending on the two enables. Assumes the
// inputs are synchronous and that the enables are stable around an event.
module mchk_fsm
    import mchk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mc_evt,
    input  logic cs_req,
    input  logic cfg_me,
    input  logic cfg_emc,
    output logic irq,
    output logic halted
);

    mchk_state_e state_q, state_d;
    logic        mc_halt, mc_int, running;

    // Classify the current machine-check event.
    always_comb begin
        running = (state_q == ST_RUN);
        mc_halt = mc_evt && cfg_emc && !cfg_me;
        mc_int  = mc_evt && cfg_emc && cfg_me;
    end

    // Next-state logic: RUN moves to HALT on any halting cause, HALT is sticky.
    always_comb begin
        state_d = state_q;
        if (running && (cs_req || mc_halt)) begin
            state_d = ST_HALT;
        end
    end

    // State register, cleared only by hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Interrupt request: a registered pulse, raised only while running and
    // not about to halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= running && !cs_req && mc_int;
        end
    end

    assign halted = (state_q == ST_HALT);

    // R8: the halted state is left only through reset.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: no interrupt is reported once halted.
    a_r8_no_irq_halted: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halted) |-> !irq);

    // R5: an interrupt needs the external enable in the cycle before.
    a_r5_irq_needs_emc: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_emc) && $past(cfg_me));

    // R4: a halting event with the machine-check enable clear gives no interrupt.
    a_r4_halt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_evt && cfg_emc && !cfg_me) |=> !irq && halted);

endmodule

// File: rtl/mchk_ctrl.sv
// Module: mchk_ctrl (top)
// Machine-check and checkstop controller. It synchronizes both asynchronous
// active-low requests, qualifies the machine-check request by its hold
// time, and drives the clock enable, the output enable and the open-drain
// status line from the sticky halted state. Assumes rst_n is synchronous to
// clk and that an external pull-up sits on cs_out_n.
module mchk_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_in_n,
    input  logic cs_in_n,
    input  logic cfg_me,
    input  logic cfg_emc,
    output logic mc_irq,
    output logic clk_en,
    output logic out_en,
    output logic cs_out_oe,
    output wire  cs_out_n
);

    logic mc_sync_n, cs_sync_n, mc_evt, halted;

    mchk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mc_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (mc_in_n),
        .q_sync  (mc_sync_n)
    );

    mchk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cs_in_n),
        .q_sync  (cs_sync_n)
    );

    mchk_qual #(.HOLD_CYC(HOLD_CYC)) u_mc_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (mc_sync_n),
        .evt   (mc_evt)
    );

    mchk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mc_evt  (mc_evt),
        .cs_req  (!cs_sync_n),
        .cfg_me  (cfg_me),
        .cfg_emc (cfg_emc),
        .irq     (mc_irq),
        .halted  (halted)
    );

    // Output stage: everything stops and floats while halted.
    always_comb begin
        clk_en    = !halted;
        out_en    = !halted;
        cs_out_oe = halted;
    end

    // Open-drain status line: pull low or release, never drive high.
    assign cs_out_n = cs_out_oe ? 1'b0 : 1'bz;

    // R6: a synchronized checkstop request always halts on the next edge.
    a_r6_cs_halts: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_sync_n |=> !clk_en && !out_en);

    // R7: the status line is driven exactly while the clock is stopped.
    a_r7_oe_matches: assert property (@(posedge clk) disable iff (!rst_n)
        cs_out_oe == !clk_en);

    // R1: the first cycle after reset is running with the line released.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> clk_en && out_en && !cs_out_oe && !mc_irq);

endmodule

// File: tb/mchk_ctrl_bench.sv
// Bench for mchk_ctrl. A scoreboard compares an expected-event queue, filled
// by the driver tasks, with an observed-event queue, filled by a monitor at
// each falling clock edge.
module mchk_ctrl_bench;

    localparam time CLK_PER = 10ns;
    localparam int  EV_IRQ  = 1;
    localparam int  EV_HALT = 2;
    localparam int  EV_WIDE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_in_n = 1'b1;
    logic cs_in_n = 1'b1;
    logic cfg_me = 1'b0;
    logic cfg_emc = 1'b0;
    logic mc_irq, clk_en, out_en, cs_out_oe;
    tri1  cs_line;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int obs_q[$];
    logic prev_clk_en = 1'b1;
    int   irq_run = 0;

    always #(CLK_PER / 2) clk = ~clk;

    mchk_ctrl u_mchk_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_in_n   (mc_in_n),
        .cs_in_n   (cs_in_n),
        .cfg_me    (cfg_me),
        .cfg_emc   (cfg_emc),
        .mc_irq    (mc_irq),
        .clk_en    (clk_en),
        .out_en    (out_en),
        .cs_out_oe (cs_out_oe),
        .cs_out_n  (cs_line)
    );

    // Monitor: record interrupt pulses, over-long pulses and halt entries.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mc_irq) begin
                if (irq_run == 0) obs_q.push_back(EV_IRQ);
                if (irq_run == 1) obs_q.push_back(EV_WIDE);
                irq_run++;
            end else begin
                irq_run = 0;
            end
            if (prev_clk_en && !clk_en) obs_q.push_back(EV_HALT);
            prev_clk_en = clk_en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard: pop and compare the observed events against the expected ones.
    task automatic score(input string req);
        chk({req, " event count"}, obs_q.size(), exp_q.size());
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            chk({req, " event kind"}, obs_q.pop_front(), exp_q.pop_front());
        end
        exp_q.delete();
        obs_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 clk_en in reset", clk_en, 1);
        chk("R1 cs_out_oe in reset", cs_out_oe, 0);
        rst_n = 1'b1;
        prev_clk_en = 1'b1;
        irq_run = 0;
        exp_q.delete();
        obs_q.delete();
        @(negedge clk);
    endtask

    task automatic mc_pulse(input int low_cycles);
        mc_in_n = 1'b0;
        repeat (low_cycles) @(negedge clk);
        mc_in_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_running(input string req);
        chk({req, " clk_en"}, clk_en, 1);
        chk({req, " out_en"}, out_en, 1);
        chk({req, " line"}, cs_line, 1);
    endtask

    task automatic check_halted(input string req);
        chk({req, " clk_en"}, clk_en, 0);
        chk({req, " out_en"}, out_en, 0);
        chk({req, " cs_out_oe"}, cs_out_oe, 1);
        chk({req, " line"}, cs_line, 0);
    endtask

    initial begin : main
        do_reset();
        check_running("R1 after reset");
        chk("R1 mc_irq", mc_irq, 0);

        // R3: interrupt mode, minimal hold, then a long hold gives one pulse.
        cfg_me = 1'b1; cfg_emc = 1'b1;
        @(negedge clk);
        mc_pulse(2); exp_q.push_back(EV_IRQ); score("R3 short hold irq");
        mc_pulse(7); exp_q.push_back(EV_IRQ); score("R3 long hold single irq");
        mc_pulse(3); mc_pulse(3);
        exp_q.push_back(EV_IRQ); exp_q.push_back(EV_IRQ); score("R3 rearm after high");

        // R2: a one-cycle glitch is ignored in interrupt and halt modes.
        mc_pulse(1); score("R2 glitch irq mode");
        cfg_me = 1'b0;
        @(negedge clk);
        mc_pulse(1); score("R2 glitch halt mode");
        check_running("R2 still running");

        // R5: external enable clear ignores events in both settings of cfg_me.
        cfg_emc = 1'b0;
        @(negedge clk);
        mc_pulse(4); score("R5 ignored me=0");
        cfg_me = 1'b1;
        @(negedge clk);
        mc_pulse(4); score("R5 ignored me=1");
        check_running("R5 still running");

        // R4: external enable only gives a halt without an interrupt.
        cfg_me = 1'b0; cfg_emc = 1'b1;
        @(negedge clk);
        mc_pulse(3); exp_q.push_back(EV_HALT); score("R4 halt no irq");
        check_halted("R7 halted by mc");

        // R8: sticky halt, no interrupt even with interrupts enabled.
        cfg_me = 1'b1;
        @(negedge clk);
        mc_pulse(4); score("R8 no irq while halted");
        repeat (20) @(negedge clk);
        check_halted("R8 still halted");

        do_reset();
        check_running("R8 reset clears halt");

        // R6: one-cycle checkstop with every enable clear still halts.
        cfg_me = 1'b0; cfg_emc = 1'b0;
        @(negedge clk);
        cs_in_n = 1'b0;
        @(negedge clk);
        cs_in_n = 1'b1;
        repeat (8) @(negedge clk);
        exp_q.push_back(EV_HALT); score("R6 checkstop unmasked");
        check_halted("R7 halted by checkstop");

        // R6: checkstop also wins with interrupts enabled.
        do_reset();
        cfg_me = 1'b1; cfg_emc = 1'b1;
        @(negedge clk);
        cs_in_n = 1'b0;
        repeat (5) @(negedge clk);
        cs_in_n = 1'b1;
        repeat (8) @(negedge clk);
        exp_q.push_back(EV_HALT); score("R6 checkstop with enables");
        check_halted("R8 halted after release");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule